// File: doc/BRIEF.md
# Two-Wire Block Transfer Link

This block moves a block of bytes from a sending side to a receiving side. Each side runs on its own clock and reset, and the two clocks need not be related. Three signals cross between the sides: an 8-bit data bus and an active-low "byte offered" line driven by the sender, and an active-high busy line driven by the receiver. The link uses a four-phase handshake on these two control wires and has no other flow control. The busy line is the only back-pressure. The sender offers no byte while busy is high, and it withdraws an offer only after busy has risen. Each side passes the other side's control line through a two-flop synchroniser before acting on it.

Software on the sending side first fills a small local buffer through a write port. It then starts a transfer of the half-open address range [first, last). Software on the receiving side starts a matching range into its own buffer and reads the bytes back through a read port. Each side raises its done output when its range is complete. A range with first >= last completes at once and moves neither control wire. At reset the offer line sits high (no offer) and busy sits high (not ready). No byte moves until the receiver has been started and drops busy, so it does not matter which side starts first.

Top module: `hs_link`

## Requirements
- R1: After reset, data_ready_n is 1, busy is 1, and tx_done and rx_done are both 0.
- R2: While the receiver has not been started, busy stays high and a started sender never drives data_ready_n low.
- R3: link_data does not change during any cycle in which data_ready_n is low.
- R4: A started block of last-first bytes arrives intact. After both done outputs are high, receive buffer address a holds the byte that was written to transmit buffer address a, for every a in [first, last).
- R5: A range with first >= last raises done on that side within a few cycles and produces no edge on data_ready_n or busy.
- R6: The transfer completes whether the sender or the receiver is started first.
- R7: busy rises only while data_ready_n is low, which means a byte is on offer.
- R8: data_ready_n returns high only while busy is high, which means the byte has been taken.
- R9: busy falls only while data_ready_n is high.
- R10: data_ready_n falls only while busy is low.
- R11: While tx_done is high, data_ready_n is high.
- R12: The receiver writes only addresses inside its started range. Other receive buffer entries keep their earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_s | input | 1 | Sender clock |
| rst_s_n | input | 1 | Sender reset, active low |
| tx_wr_en | input | 1 | Write strobe for the transmit buffer |
| tx_wr_addr | input | 4 | Transmit buffer write address |
| tx_wr_data | input | 8 | Transmit buffer write data |
| tx_start | input | 1 | One-cycle pulse that starts a send; honoured when idle or done |
| tx_first | input | 5 | First transmit address (inclusive) |
| tx_last | input | 5 | End transmit address (exclusive) |
| tx_done | output | 1 | Send range complete |
| clk_r | input | 1 | Receiver clock |
| rst_r_n | input | 1 | Receiver reset, active low |
| rx_start | input | 1 | One-cycle pulse that starts a receive; honoured when idle or done |
| rx_first | input | 5 | First receive address (inclusive) |
| rx_last | input | 5 | End receive address (exclusive) |
| rx_done | output | 1 | Receive range complete |
| rx_rd_addr | input | 4 | Receive buffer read address |
| rx_rd_data | output | 8 | Receive buffer read data, combinational |
| link_data | output | 8 | Data bus from sender to receiver |
| data_ready_n | output | 1 | Byte offered, active low, driven by the sender |
| busy | output | 1 | Receiver busy, active high |

## Verification
The bench runs the two sides on clocks with unrelated periods and alternates which side is started first. A design that ignores the reset level of busy would let a sender that starts alone put a byte on the bus to nobody. Single-byte ranges, ranges that end at the top of the buffer and ranges with a nonzero start expose off-by-one errors in the end compare: such a design drops the last byte or writes one byte past the range, and the neighbouring receive entry that must survive then changes. Zero-length ranges catch a design that offers one spurious byte, and the edge counters on both wires see it.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [2:0] {
    TX_IDLE, TX_WAIT_FREE, TX_OFFER, TX_WAIT_TAKE, TX_DONE
  } tx_state_t;

  typedef enum logic [1:0] {
    RX_IDLE, RX_WAIT_BYTE, RX_WAIT_RELEASE, RX_DONE
  } rx_state_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/hs_sender.sv
module hs_sender
  import hs_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          start,
  input  logic [AW:0]   first,
  input  logic [AW:0]   last,
  input  logic          busy_in,
  output logic [DW-1:0] link_data,
  output logic          data_ready_n,
  output logic          done
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   ptr, end_q;
  logic [AW:0]   ptr_nxt;
  logic          busy_s;
  tx_state_t     state;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  hs_sync #(.STAGES(2), .RST_VAL(1'b1)) u_busy_sync (
    .clk(clk), .rst_n(rst_n), .async_in(busy_in), .sync_out(busy_s)
  );

  assign ptr_nxt = ptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= TX_IDLE;
      ptr          <= '0;
      end_q        <= '0;
      link_data    <= '0;
      data_ready_n <= 1'b1;
    end else begin
      case (state)
        TX_IDLE, TX_DONE: begin
          if (start) begin
            ptr   <= first;
            end_q <= last;
            state <= (first >= last) ? TX_DONE : TX_WAIT_FREE;
          end
        end
        TX_WAIT_FREE: begin
          if (!busy_s) begin
            link_data <= mem[ptr[AW-1:0]];
            state     <= TX_OFFER;
          end
        end
        TX_OFFER: begin
          data_ready_n <= 1'b0;
          state        <= TX_WAIT_TAKE;
        end
        TX_WAIT_TAKE: begin
          if (busy_s) begin
            data_ready_n <= 1'b1;
            ptr          <= ptr_nxt;
            state        <= (ptr_nxt == end_q) ? TX_DONE : TX_WAIT_FREE;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  assign done = (state == TX_DONE);
endmodule

// File: rtl/hs_receiver.sv
module hs_receiver
  import hs_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW:0]   first,
  input  logic [AW:0]   last,
  input  logic          data_ready_n_in,
  input  logic [DW-1:0] link_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          done
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   ptr, end_q;
  logic          drn_s;
  logic          take;
  rx_state_t     state;

  hs_sync #(.STAGES(2), .RST_VAL(1'b1)) u_drn_sync (
    .clk(clk), .rst_n(rst_n), .async_in(data_ready_n_in), .sync_out(drn_s)
  );

  assign take = (state == RX_WAIT_BYTE) && !drn_s;

  always_ff @(posedge clk) begin
    if (take) mem[ptr[AW-1:0]] <= link_data;
  end

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      ptr   <= '0;
      end_q <= '0;
      busy  <= 1'b1;
    end else begin
      case (state)
        RX_IDLE, RX_DONE: begin
          if (start) begin
            ptr   <= first;
            end_q <= last;
            if (first >= last) begin
              state <= RX_DONE;
            end else begin
              busy  <= 1'b0;
              state <= RX_WAIT_BYTE;
            end
          end
        end
        RX_WAIT_BYTE: begin
          if (take) begin
            busy  <= 1'b1;
            ptr   <= ptr + 1'b1;
            state <= RX_WAIT_RELEASE;
          end
        end
        RX_WAIT_RELEASE: begin
          if (drn_s) begin
            if (ptr == end_q) begin
              state <= RX_DONE;
            end else begin
              busy  <= 1'b0;
              state <= RX_WAIT_BYTE;
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign done = (state == RX_DONE);
endmodule

// File: rtl/hs_link.sv
module hs_link #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk_s,
  input  logic          rst_s_n,
  input  logic          tx_wr_en,
  input  logic [AW-1:0] tx_wr_addr,
  input  logic [DW-1:0] tx_wr_data,
  input  logic          tx_start,
  input  logic [AW:0]   tx_first,
  input  logic [AW:0]   tx_last,
  output logic          tx_done,
  input  logic          clk_r,
  input  logic          rst_r_n,
  input  logic          rx_start,
  input  logic [AW:0]   rx_first,
  input  logic [AW:0]   rx_last,
  output logic          rx_done,
  input  logic [AW-1:0] rx_rd_addr,
  output logic [DW-1:0] rx_rd_data,
  output logic [DW-1:0] link_data,
  output logic          data_ready_n,
  output logic          busy
);
  hs_sender #(.DW(DW), .AW(AW)) u_tx (
    .clk(clk_s), .rst_n(rst_s_n),
    .wr_en(tx_wr_en), .wr_addr(tx_wr_addr), .wr_data(tx_wr_data),
    .start(tx_start), .first(tx_first), .last(tx_last),
    .busy_in(busy), .link_data(link_data),
    .data_ready_n(data_ready_n), .done(tx_done)
  );

  hs_receiver #(.DW(DW), .AW(AW)) u_rx (
    .clk(clk_r), .rst_n(rst_r_n),
    .start(rx_start), .first(rx_first), .last(rx_last),
    .data_ready_n_in(data_ready_n), .link_data(link_data),
    .rd_addr(rx_rd_addr), .rd_data(rx_rd_data),
    .busy(busy), .done(rx_done)
  );
endmodule

// File: rtl/hs_link_chk.sv
module hs_link_chk #(
  parameter int DW = 8
) (
  input logic          clk_s,
  input logic          rst_s_n,
  input logic          clk_r,
  input logic          rst_r_n,
  input logic [DW-1:0] link_data,
  input logic          data_ready_n,
  input logic          busy,
  input logic          tx_done
);
  // R3
  data_hold_chk: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    !data_ready_n |-> $stable(link_data));

  // R7
  busy_rise_chk: assert property (@(posedge clk_r) disable iff (!rst_r_n)
    $rose(busy) |-> !data_ready_n);

  // R8
  offer_release_chk: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    $rose(data_ready_n) |-> busy);

  // R9
  busy_fall_chk: assert property (@(posedge clk_r) disable iff (!rst_r_n)
    $fell(busy) |-> data_ready_n);

  // R10
  offer_start_chk: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    $fell(data_ready_n) |-> !busy);

  // R11
  done_idle_chk: assert property (@(posedge clk_s) disable iff (!rst_s_n)
    tx_done |-> data_ready_n);
endmodule

bind hs_link hs_link_chk #(.DW(DW)) u_chk (
  .clk_s(clk_s), .rst_s_n(rst_s_n), .clk_r(clk_r), .rst_r_n(rst_r_n),
  .link_data(link_data), .data_ready_n(data_ready_n), .busy(busy),
  .tx_done(tx_done)
);

// File: tb/tb_hs_link.sv
module tb_hs_link;
  localparam int CLK_PERIOD = 10;
  localparam int RX_PERIOD  = CLK_PERIOD + 4;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int NVEC = 5;
  // entry: {first[4:0], last[4:0], receiver_first}
  localparam logic [10:0] VEC [NVEC] = '{
    {5'd0,  5'd4,  1'b0},
    {5'd3,  5'd9,  1'b1},
    {5'd15, 5'd16, 1'b0},
    {5'd0,  5'd16, 1'b1},
    {5'd7,  5'd12, 1'b0}
  };

  logic clk_s = 0, clk_r = 0, rst_s_n = 0, rst_r_n = 0;
  logic tx_wr_en = 0, tx_start = 0, rx_start = 0, tx_done, rx_done;
  logic [AW-1:0] tx_wr_addr = '0, rx_rd_addr = '0;
  logic [DW-1:0] tx_wr_data = '0, rx_rd_data, link_data;
  logic [AW:0]   tx_first = '0, tx_last = '0, rx_first = '0, rx_last = '0;
  logic data_ready_n, busy;
  int n_checks = 0, n_fail = 0, drn_edges = 0, busy_edges = 0;

  always #(CLK_PERIOD/2) clk_s = ~clk_s;
  always #(RX_PERIOD/2)  clk_r = ~clk_r;

  hs_link #(.DW(DW), .AW(AW)) dut (.*);

  always @(data_ready_n) drn_edges++;
  always @(busy) busy_edges++;

  function automatic logic [DW-1:0] pat(int a, int v);
    return DW'(a * 29 + v * 7 + 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_tx(int v);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk_s);
      tx_wr_en = 1; tx_wr_addr = AW'(a); tx_wr_data = pat(a, v);
    end
    @(negedge clk_s); tx_wr_en = 0;
  endtask

  task automatic start_tx(int f, int l);
    @(negedge clk_s); tx_first = (AW+1)'(f); tx_last = (AW+1)'(l); tx_start = 1;
    @(negedge clk_s); tx_start = 0;
  endtask

  task automatic start_rx(int f, int l);
    @(negedge clk_r); rx_first = (AW+1)'(f); rx_last = (AW+1)'(l); rx_start = 1;
    @(negedge clk_r); rx_start = 0;
  endtask

  task automatic wait_both();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk_s); #1;
      if (tx_done && rx_done) break;
    end
  endtask

  task automatic rd(int a, output logic [DW-1:0] d);
    @(negedge clk_r); rx_rd_addr = AW'(a); #1; d = rx_rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk_s);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int e0, e1;
    repeat (3) @(negedge clk_s);
    rst_s_n = 1; rst_r_n = 1;
    @(negedge clk_s); #1;
    // R1 reset levels
    check(data_ready_n == 1, "R1 data_ready_n", data_ready_n, 1);
    check(busy == 1, "R1 busy", busy, 1);
    check(tx_done == 0 && rx_done == 0, "R1 done", tx_done + rx_done, 0);

    // R2: sender alone must not offer
    load_tx(9);
    start_tx(0, 2);
    e0 = drn_edges;
    repeat (60) @(negedge clk_s);
    #1;
    check(drn_edges == e0 && data_ready_n == 1, "R2 no offer", drn_edges - e0, 0);
    check(tx_done == 0 && busy == 1, "R2 held", tx_done, 0);
    start_rx(0, 2);
    wait_both();
    check(tx_done && rx_done, "R6 sender first done", tx_done & rx_done, 1);
    for (int a = 0; a < 2; a++) begin
      rd(a, d); check(d == pat(a, 9), "R4 sender-first byte", d, pat(a, 9));
    end

    // table of blocks
    for (int v = 0; v < NVEC; v++) begin
      int f, l;
      f = int'(VEC[v][10:6]); l = int'(VEC[v][5:1]);
      load_tx(v);
      if (VEC[v][0]) begin start_rx(f, l); repeat (20) @(negedge clk_s); start_tx(f, l); end
      else begin start_tx(f, l); repeat (20) @(negedge clk_s); start_rx(f, l); end
      wait_both();
      check(tx_done && rx_done, "R6 block done", tx_done & rx_done, 1);
      for (int a = f; a < l; a++) begin
        rd(a, d); check(d == pat(a, v), "R4 block byte", d, pat(a, v));
      end
    end

    // R12: neighbours of last block keep block 3 contents
    rd(6, d);  check(d == pat(6, 3),  "R12 below range", d, pat(6, 3));
    rd(12, d); check(d == pat(12, 3), "R12 above range", d, pat(12, 3));

    // R5: zero-length ranges
    e0 = drn_edges; e1 = busy_edges;
    start_tx(4, 4);
    start_rx(4, 4);
    repeat (10) @(negedge clk_s);
    #1;
    check(tx_done && rx_done, "R5 empty done", tx_done & rx_done, 1);
    check(drn_edges == e0, "R5 data_ready_n quiet", drn_edges - e0, 0);
    check(busy_edges == e1, "R5 busy quiet", busy_edges - e1, 0);
    start_tx(9, 3);
    repeat (4) @(negedge clk_s);
    #1;
    check(tx_done && drn_edges == e0, "R5 inverted range", drn_edges - e0, 0);
    // R11 line idle while done
    check(data_ready_n == 1, "R11 idle at done", data_ready_n, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule